// File: doc/BRIEF.md
# Indexed FEC Packet Dropper

This block sits in a transmit path right after a forward-error-correction encoder and throws away chosen packets so that loss on a network can be reproduced on purpose. The encoder turns every original frame into a group of four coded packets, and each coded packet carries its position in the group (0 to 3) in its header. The dropper reads that position from the first beat of every packet. It discards the whole packet when two conditions hold: dropping is enabled, and the matching bit of a programmable drop mask is set. Every other packet goes through untouched. Dropping three or more packets of a group is the way to force the decoder downstream into a failure.

Packets move on a valid/ready beat stream with a last flag. A forwarded beat is passed combinationally: `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`, so back-pressure from the sink reaches the source in the same cycle. A dropped packet never asserts `out_valid`. Its beats are taken at the input every cycle whatever `out_ready` is. Software reaches three words through a simple write-strobe register port with a combinational read: the drop mask, the enable, and a count of dropped packets.

Top module: `fec_index_dropper`

## Requirements
- R1: After reset, the drop mask is 0, dropping is disabled and the dropped-packet count is 0, and all three read back as 0.
- R2: Register map on `reg_addr`: 0x0 holds the mask (bit n selects group index n and is written from `reg_wdata[3:0]`). 0x4 holds the enable in bit 0 (1 = enabled, 0 = pass everything). 0x8 reads the dropped-packet count and ignores writes. Any other address reads 0.
- R3: The first beat of a packet carries the Ethertype in bits [15:0] and the group index in bits [17:16]. A packet counts as coded when its Ethertype equals the parameter `FEC_TYPE` (default 0xBABE).
- R4: When enabled, a coded packet whose index bit is set in the mask is dropped whole. On every one of its beats, `in_ready` is 1 and `out_valid` is 0. For example, mask 0x5 drops indices 0 and 2, and mask 0x7 drops indices 0, 1 and 2 but passes index 3.
- R5: A mask of 0 drops nothing, and with the enable at 0 every packet passes whatever the mask holds.
- R6: Packets whose Ethertype is not `FEC_TYPE` always pass, whatever the mask and enable hold.
- R7: A forwarded beat leaves with the same data and last flag it entered with. For such a beat, `out_valid` equals `in_valid` and `in_ready` equals `out_ready`.
- R8: A write to the mask or the enable made during a packet takes effect only from the next packet's first beat. The drop decision for the packet in progress does not change.
- R9: The dropped-packet count rises by exactly one when the last beat of a dropped packet is accepted, and does not change otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | DATA_W (32) | Input beat data; the first beat holds the header |
| in_last | input | 1 | Last beat of the input packet |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Sink can take a beat |
| out_data | output | DATA_W (32) | Output beat data |
| out_last | output | 1 | Last beat of the output packet |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Register byte address |
| reg_wdata | input | GROUP (4) | Register write data |
| reg_rdata | output | CNT_W (16) | Register read data (combinational) |

## Verification
Two events can land in the same cycle: a mask write and the acceptance of a beat in the middle of a packet. The bench provokes this by raising the write strobe on the exact cycle that the second beat of a forwarded coded packet is accepted. The write selects that packet's own index. The result is judged at the ports: the remaining beats of that packet must still appear on the output, and the next packet with the same index must vanish and raise the count by one. A second pairing checks the sink's back-pressure against a drop. With `out_ready` low, a dropped packet must still be consumed, while a forwarded one must stall.

// File: rtl/fidrop_pkg.sv
`timescale 1ns/1ps
package fidrop_pkg;
  localparam int unsigned ETYPE_W   = 16;
  localparam int unsigned ETYPE_LSB = 0;
  localparam int unsigned IDX_LSB   = 16;

  localparam logic [3:0] ADR_MASK  = 4'h0;
  localparam logic [3:0] ADR_EN    = 4'h4;
  localparam logic [3:0] ADR_COUNT = 4'h8;

  typedef enum logic [1:0] {
    VERDICT_PASS_OTHER = 2'd0,
    VERDICT_PASS_FEC   = 2'd1,
    VERDICT_DROP       = 2'd2
  } verdict_e;
endpackage

// File: rtl/fidrop_regs.sv
`timescale 1ns/1ps
module fidrop_regs #(
  parameter int unsigned GROUP  = 4,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [GROUP-1:0]  reg_wdata,
  input  logic [CNT_W-1:0]  drop_count,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic [GROUP-1:0]  mask_q,
  output logic              en_q
);
  import fidrop_pkg::*;

  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(ADR_MASK);
  localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(ADR_EN);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(ADR_COUNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      en_q   <= 1'b0;
    end else if (reg_we) begin
      if (reg_addr == A_MASK) mask_q <= reg_wdata;
      if (reg_addr == A_EN)   en_q   <= reg_wdata[0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_MASK)       reg_rdata = CNT_W'(mask_q);
    else if (reg_addr == A_EN)    reg_rdata = CNT_W'(en_q);
    else if (reg_addr == A_COUNT) reg_rdata = drop_count;
  end

  // R2: settings only move on a write strobe
  p_settings_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ($stable(mask_q) && $stable(en_q)));
endmodule

// File: rtl/fidrop_classify.sv
`timescale 1ns/1ps
module fidrop_classify #(
  parameter int unsigned GROUP    = 4,
  parameter logic [15:0] FEC_TYPE = 16'hBABE,
  localparam int unsigned IDX_W   = $clog2(GROUP),
  localparam int unsigned HDR_W   = fidrop_pkg::IDX_LSB + IDX_W
) (
  input  logic [HDR_W-1:0] hdr,
  input  logic [GROUP-1:0] mask,
  input  logic             en,
  output fidrop_pkg::verdict_e verdict
);
  import fidrop_pkg::*;

  logic [ETYPE_W-1:0] etype;
  logic [IDX_W-1:0]   idx;
  logic               is_fec;

  assign etype  = hdr[ETYPE_LSB +: ETYPE_W];
  assign idx    = hdr[IDX_LSB +: IDX_W];
  assign is_fec = (etype == FEC_TYPE);

  always_comb begin
    if (!is_fec)                verdict = VERDICT_PASS_OTHER;
    else if (en && mask[idx])   verdict = VERDICT_DROP;
    else                        verdict = VERDICT_PASS_FEC;
  end
endmodule

// File: rtl/fidrop_gate.sv
`timescale 1ns/1ps
module fidrop_gate #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fidrop_pkg::verdict_e verdict,
  output logic              first_beat,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic [CNT_W-1:0]  drop_count
);
  import fidrop_pkg::*;

  logic in_pkt_q;
  logic drop_q;
  logic drop_now;
  logic beat_acc;

  assign first_beat = !in_pkt_q;
  assign drop_now   = first_beat ? (verdict == VERDICT_DROP) : drop_q;

  assign out_valid  = in_valid && !drop_now;
  assign in_ready   = drop_now || out_ready;
  assign out_data   = in_data;
  assign out_last   = in_last;
  assign beat_acc   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt_q   <= 1'b0;
      drop_q     <= 1'b0;
      drop_count <= '0;
    end else if (beat_acc) begin
      in_pkt_q <= !in_last;
      if (first_beat) drop_q <= drop_now;
      if (drop_now && in_last) drop_count <= drop_count + 1'b1;
    end
  end

  // R8: the drop decision is frozen while a packet is in flight
  p_decision_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt_q && $past(in_pkt_q)) |-> $stable(drop_q));

  // R4: a dropped beat is consumed and never shown downstream
  p_drop_consumed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && verdict == VERDICT_DROP && first_beat) |-> (in_ready && !out_valid));

  // R6: foreign traffic at a packet start always reaches the output
  p_other_passes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && first_beat && verdict == VERDICT_PASS_OTHER) |-> out_valid);

  // R9: the counter steps by at most one
  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == $past(drop_count)) || (drop_count == $past(drop_count) + 1'b1));
endmodule

// File: rtl/fec_index_dropper.sv
`timescale 1ns/1ps
module fec_index_dropper #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned GROUP    = 4,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CNT_W    = 16,
  parameter logic [15:0] FEC_TYPE = 16'hBABE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [GROUP-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata
);
  import fidrop_pkg::*;

  localparam int unsigned IDX_W = $clog2(GROUP);
  localparam int unsigned HDR_W = IDX_LSB + IDX_W;

  logic [GROUP-1:0] mask_q;
  logic             en_q;
  logic [CNT_W-1:0] drop_count;
  verdict_e         verdict;
  logic             first_beat;

  fidrop_regs #(.GROUP(GROUP), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .drop_count(drop_count), .reg_rdata(reg_rdata),
    .mask_q(mask_q), .en_q(en_q)
  );

  fidrop_classify #(.GROUP(GROUP), .FEC_TYPE(FEC_TYPE)) u_classify (
    .hdr(in_data[HDR_W-1:0]), .mask(mask_q), .en(en_q), .verdict(verdict)
  );

  fidrop_gate #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .verdict(verdict), .first_beat(first_beat),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .drop_count(drop_count)
  );

  // R7: a beat shown downstream is never lost to back-pressure
  p_fwd_backpressure_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/test_fec_index_dropper.sv
`timescale 1ns/1ps
module test_fec_index_dropper;
  localparam int DATA_W = 32;
  localparam int GROUP  = 4;
  localparam int ADDR_W = 4;
  localparam int CNT_W  = 16;
  localparam logic [15:0] FECT = 16'hBABE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [DATA_W-1:0] in_data = '0;
  logic in_ready, out_valid, out_last;
  logic [DATA_W-1:0] out_data;
  logic reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [GROUP-1:0] reg_wdata = '0;
  logic [CNT_W-1:0] reg_rdata;

  fec_index_dropper #(.DATA_W(DATA_W), .GROUP(GROUP), .ADDR_W(ADDR_W),
                      .CNT_W(CNT_W), .FEC_TYPE(FECT)) i_fec_index_dropper (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int drops_expected = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic [15:0] etype;
    logic [1:0]  idx;
    logic [3:0]  beats;
    logic [3:0]  mask;
    logic        en;
    logic        pass;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TAB [NV] = '{
    '{16'hBABE, 2'd0, 4'd3, 4'h5, 1'b1, 1'b0},
    '{16'hBABE, 2'd1, 4'd2, 4'h5, 1'b1, 1'b1},
    '{16'hBABE, 2'd2, 4'd4, 4'h5, 1'b1, 1'b0},
    '{16'hBABE, 2'd3, 4'd1, 4'h5, 1'b1, 1'b1},
    '{16'h0800, 2'd0, 4'd3, 4'h7, 1'b1, 1'b1},
    '{16'hBABE, 2'd1, 4'd2, 4'h7, 1'b1, 1'b0},
    '{16'hBABE, 2'd3, 4'd2, 4'h7, 1'b1, 1'b1},
    '{16'hBABE, 2'd0, 4'd2, 4'h0, 1'b1, 1'b1},
    '{16'hBABE, 2'd2, 4'd3, 4'h7, 1'b0, 1'b1},
    '{16'hBABE, 2'd3, 4'd2, 4'hF, 1'b1, 1'b0},
    '{16'h0800, 2'd2, 4'd1, 4'hF, 1'b1, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [GROUP-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] exp,
                    input string req);
    reg_addr = a; #1;
    chk(reg_rdata == exp, req, "register read", 32'(reg_rdata), 32'(exp));
  endtask

  function automatic logic [DATA_W-1:0] beat_word(input logic [15:0] et,
      input logic [1:0] ix, input int b);
    if (b == 0) return {8'h3C, 6'h15, ix, et};
    return 32'hC0DE0000 + 32'(b);
  endfunction

  // Streams one packet with out_ready high and checks each beat.
  task automatic send(input logic [15:0] et, input logic [1:0] ix, input int n,
                      input bit pass, input string req);
    for (int b = 0; b < n; b++) begin
      in_valid = 1'b1; in_data = beat_word(et, ix, b); in_last = (b == n - 1);
      #3;
      chk(out_valid == pass, req, "out_valid", 32'(out_valid), 32'(pass));
      chk(in_ready == 1'b1, req, "in_ready", 32'(in_ready), 32'd1);
      if (pass) begin
        chk(out_data == in_data, "R7", "out_data", out_data, in_data);
        chk(out_last == in_last, "R7", "out_last", 32'(out_last), 32'(in_last));
      end
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    // R1: reset state
    rd(4'h0, 16'h0, "R1");
    rd(4'h4, 16'h0, "R1");
    rd(4'h8, 16'h0, "R1");
    // R2: map and read-only count
    wr(4'h0, 4'hA); rd(4'h0, 16'hA, "R2");
    wr(4'h4, 4'h1); rd(4'h4, 16'h1, "R2");
    wr(4'h8, 4'hF); rd(4'h8, 16'h0, "R2");
    rd(4'hC, 16'h0, "R2");
    wr(4'h4, 4'h0);

    // Table walk: R3 header, R4 drops, R5 mask 0 / disabled, R6 foreign
    for (int i = 0; i < NV; i++) begin
      wr(4'h0, TAB[i].mask);
      wr(4'h4, {3'b000, TAB[i].en});
      send(TAB[i].etype, TAB[i].idx, int'(TAB[i].beats), TAB[i].pass,
           TAB[i].pass ? ((TAB[i].etype != FECT) ? "R6" : "R5") : "R4");
      if (!TAB[i].pass) drops_expected++;
    end
    rd(4'h8, CNT_W'(drops_expected), "R9");

    // R7: back-pressure on a forwarded packet stalls the source
    wr(4'h0, 4'h1); wr(4'h4, 4'h1);
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = beat_word(FECT, 2'd2, 0); in_last = 1'b1;
    #3;
    chk(out_valid == 1'b1, "R7", "stalled out_valid", 32'(out_valid), 32'd1);
    chk(in_ready == 1'b0, "R7", "stalled in_ready", 32'(in_ready), 32'd0);
    out_ready = 1'b1; #1;
    chk(in_ready == 1'b1, "R7", "released in_ready", 32'(in_ready), 32'd1);
    @(posedge clk); #1;
    in_valid = 1'b0;
    // R4: dropped packet is consumed even with out_ready low
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = beat_word(FECT, 2'd0, 0); in_last = 1'b1;
    #3;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R4", "drop under back-pressure",
        {in_ready, out_valid}, 32'b10);
    @(posedge clk); #1;
    in_valid = 1'b0; out_ready = 1'b1;
    drops_expected++;
    rd(4'h8, CNT_W'(drops_expected), "R9");

    // R8: mask write lands on a mid-packet beat of index 1
    wr(4'h0, 4'h0);
    in_valid = 1'b1; in_data = beat_word(FECT, 2'd1, 0); in_last = 1'b0;
    #3;
    chk(out_valid == 1'b1, "R8", "first beat passes", 32'(out_valid), 32'd1);
    @(posedge clk); #1;
    in_data = beat_word(FECT, 2'd1, 1);
    reg_we = 1'b1; reg_addr = 4'h0; reg_wdata = 4'h2;
    #3;
    chk(out_valid == 1'b1, "R8", "beat with write", 32'(out_valid), 32'd1);
    @(posedge clk); #1;
    reg_we = 1'b0;
    in_data = beat_word(FECT, 2'd1, 2); in_last = 1'b1;
    #3;
    chk(out_valid == 1'b1, "R8", "tail beat still passes", 32'(out_valid), 32'd1);
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0;
    rd(4'h8, CNT_W'(drops_expected), "R9");
    send(FECT, 2'd1, 2, 1'b0, "R8");
    drops_expected++;
    rd(4'h8, CNT_W'(drops_expected), "R9");

    // R9: no count for a forwarded packet
    send(FECT, 2'd3, 3, 1'b1, "R9");
    rd(4'h8, CNT_W'(drops_expected), "R9");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule